// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up before any data traffic is allowed. It never touches the memory pins itself. Instead it asks a shared access sequencer for command cycles, one at a time, and places a 2-bit operation code beside each request. The sequencer reports what it is doing through a cycle-kind bus and a step count, and this block uses that handshake to pace itself. It also holds the 12-bit mode word that the sequencer drives onto the address lines when the load-mode operation is issued.

After synchronous reset is released, the block waits until its asynchronous enable input, passed through an internal synchronizer, reads high. It then counts a parameterised power-up delay and issues, in order: one precharge-all, a parameterised number of auto-refresh operations (two by default) and one mode-register load. When the sequencer finishes that last cycle, the block raises a setup-complete flag, which stays high until the next reset. Refresh timing and refresh request generation belong to downstream blocks that key off this flag.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cmd_req`, `setup_done` and `cmd_code` are all 0.
- R2: With `init_en_async` high when reset is released, `cmd_req` first reads 1 after exactly PWRUP_CYCLES + SYNC_STAGES + 1 rising edges. Until then `cmd_code` reads 00 (no operation).
- R3: While the synchronized enable is low, the block stays idle with `cmd_req` at 0. Once the enable rises, the same PWRUP_CYCLES + SYNC_STAGES + 1 edge latency applies, counted from the rise.
- R4: The operation codes follow the fixed order 01 (precharge), then NUM_REFRESH times 10 (auto-refresh), then 11 (load mode register). The code 00 means no operation and never appears while `cmd_req` is 1.
- R5: `cmd_req` and `cmd_code` hold steady until a grant. A grant is a cycle with `cyc_type` = 01 (command) and `cyc_step` = 0. Cycle kinds 10 (data) and 11 (refresh), and kind 01 with a nonzero step, are not grants.
- R6: One edge after a grant, `cmd_req` drops and `cmd_code` stays the same. The block does not advance while `cyc_type` is nonzero. One edge after `cyc_type` reads 00, the next request is raised with the next code.
- R7: One edge after `cyc_type` returns to 00 following the load-mode grant, `setup_done` goes to 1, `cmd_req` goes to 0 and `cmd_code` goes to 00. These values hold until reset.
- R8: `mode_word` carries burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4 and write-burst mode in bit 9. Bits 8:7 and 11:10 are 0.
- R9: A reset asserted mid-sequence clears `setup_done` and the request, and the whole sequence restarts with the full power-up delay.
- R10: After initialization has started, `init_en_async` going low has no effect on the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_en_async | input | 1 | Asynchronous start enable, synchronized internally |
| cyc_type | input | 2 | Sequencer cycle kind: 00 idle, 01 command, 10 data, 11 refresh |
| cyc_step | input | STEP_W | Sequencer state count within the current cycle |
| mode_word | output | 12 | Mode-register word for the load-mode operation |
| cmd_code | output | 2 | Requested operation: 00 nop, 01 precharge, 10 auto-refresh, 11 load mode |
| cmd_req | output | 1 | Command-cycle request to the sequencer |
| setup_done | output | 1 | Initialization complete |

## Verification
The bound checker watches the handshake on every cycle. It checks that a pending request never drops or changes code without a grant, that a grant withdraws the request on the next edge, that the no-operation code never goes out with a request, that setup-complete only rises after an idle cycle, is sticky and excludes requests, and that the outputs are clear right after reset. Only the bench scenarios can show the exact power-up latency, the full operation order for every hold-off and busy length in the sweep, the rejection of each distractor cycle kind, restart after a mid-sequence reset, indifference to the enable once started, and the packed mode-word layout.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // cycle kinds reported by the shared access sequencer
  typedef enum logic [1:0] {
    CYC_IDLE = 2'b00,
    CYC_CMD  = 2'b01,
    CYC_DATA = 2'b10,
    CYC_RFSH = 2'b11
  } cyc_kind_e;

  // operation codes presented with a command request
  typedef enum logic [1:0] {
    OP_NOP       = 2'b00,
    OP_PRECHARGE = 2'b01,
    OP_AUTOREF   = 2'b10,
    OP_LOADMODE  = 2'b11
  } init_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_BUSY,
    ST_DONE
  } init_state_e;

  // pack the mode word; unlisted bits stay zero
  function automatic logic [11:0] pack_mode(input logic [2:0] blen,
                                            input logic       btype,
                                            input logic [2:0] cas,
                                            input logic       wburst);
    logic [11:0] w;
    w        = '0;
    w[2:0]   = blen;
    w[3]     = btype;
    w[6:4]   = cas;
    w[9]     = wburst;
    return w;
  endfunction

endpackage

// File: rtl/init_en_sync.sv
module init_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/init_delay_timer.sv
module init_delay_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (!expired) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/init_step_ctrl.sv
module init_step_ctrl
  import sdram_init_pkg::*;
#(
  parameter int NUM_REFRESH = 2,
  parameter int STEP_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_sync,
  input  logic              delay_done,
  input  logic [1:0]        cyc_type,
  input  logic [STEP_W-1:0] cyc_step,
  output logic              in_wait,
  output logic [1:0]        cmd_code,
  output logic              cmd_req,
  output logic              setup_done
);
  localparam int NSTEP = NUM_REFRESH + 2;
  localparam int IDX_W = $clog2(NSTEP);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSTEP - 1);

  init_state_e      state, state_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic             grant, seq_idle;

  assign grant    = (cyc_type == CYC_CMD) && (cyc_step == '0);
  assign seq_idle = (cyc_type == CYC_IDLE);
  assign in_wait  = (state == ST_WAIT);

  function automatic logic [1:0] op_at(input logic [IDX_W-1:0] i);
    if (i == '0)            return OP_PRECHARGE;
    else if (i == LAST_IDX) return OP_LOADMODE;
    else                    return OP_AUTOREF;
  endfunction

  always_comb begin
    state_n = state;
    idx_n   = idx;
    case (state)
      ST_IDLE: if (en_sync) state_n = ST_WAIT;
      ST_WAIT: if (delay_done) state_n = ST_REQ;
      ST_REQ:  if (grant) state_n = ST_BUSY;
      ST_BUSY: begin
        if (seq_idle) begin
          if (idx == LAST_IDX) begin
            state_n = ST_DONE;
          end else begin
            idx_n   = idx + IDX_W'(1);
            state_n = ST_REQ;
          end
        end
      end
      ST_DONE: state_n = ST_DONE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      cmd_req    <= 1'b0;
      cmd_code   <= OP_NOP;
      setup_done <= 1'b0;
    end else begin
      state      <= state_n;
      idx        <= idx_n;
      cmd_req    <= (state_n == ST_REQ);
      cmd_code   <= ((state_n == ST_REQ) || (state_n == ST_BUSY)) ? op_at(idx_n) : OP_NOP;
      setup_done <= (state_n == ST_DONE);
    end
  end
endmodule

// File: rtl/init_mode_reg.sv
module init_mode_reg
  import sdram_init_pkg::*;
#(
  parameter logic [2:0] BURST_LEN   = 3'b011,
  parameter logic       BURST_TYPE  = 1'b0,
  parameter logic [2:0] CAS_LAT     = 3'd2,
  parameter logic       WRITE_BURST = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [11:0] mode_word
);
  localparam logic [11:0] WORD = pack_mode(BURST_LEN, BURST_TYPE, CAS_LAT, WRITE_BURST);

  always_ff @(posedge clk) begin
    if (rst) mode_word <= WORD;
    else     mode_word <= WORD;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int         PWRUP_CYCLES = 5000,
  parameter int         NUM_REFRESH  = 2,
  parameter int         SYNC_STAGES  = 2,
  parameter int         STEP_W       = 4,
  parameter logic [2:0] BURST_LEN    = 3'b011,
  parameter logic       BURST_TYPE   = 1'b0,
  parameter logic [2:0] CAS_LAT      = 3'd2,
  parameter logic       WRITE_BURST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_en_async,
  input  logic [1:0]        cyc_type,
  input  logic [STEP_W-1:0] cyc_step,
  output logic [11:0]       mode_word,
  output logic [1:0]        cmd_code,
  output logic              cmd_req,
  output logic              setup_done
);
  logic en_sync, delay_done, in_wait;

  init_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(init_en_async), .q_sync(en_sync)
  );

  init_delay_timer #(.LIMIT(PWRUP_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .clr(!in_wait), .expired(delay_done)
  );

  init_step_ctrl #(.NUM_REFRESH(NUM_REFRESH), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .en_sync(en_sync), .delay_done(delay_done),
    .cyc_type(cyc_type), .cyc_step(cyc_step), .in_wait(in_wait),
    .cmd_code(cmd_code), .cmd_req(cmd_req), .setup_done(setup_done)
  );

  init_mode_reg #(
    .BURST_LEN(BURST_LEN), .BURST_TYPE(BURST_TYPE),
    .CAS_LAT(CAS_LAT), .WRITE_BURST(WRITE_BURST)
  ) u_mode (
    .clk(clk), .rst(rst), .mode_word(mode_word)
  );
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cyc_type,
  input logic [STEP_W-1:0] cyc_step,
  input logic [1:0]        cmd_code,
  input logic              cmd_req,
  input logic              setup_done
);
  // R1
  clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_req && !setup_done && cmd_code == 2'b00));

  // R4
  no_nop_request_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> (cmd_code != 2'b00));

  // R5
  hold_until_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !(cyc_type == 2'b01 && cyc_step == '0)) |=> (cmd_req && $stable(cmd_code)));

  // R6
  drop_on_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && cyc_type == 2'b01 && cyc_step == '0) |=> (!cmd_req && $stable(cmd_code)));

  // R7
  done_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(setup_done) |-> ($past(cyc_type) == 2'b00));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    setup_done |=> setup_done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    setup_done |-> (!cmd_req && cmd_code == 2'b00));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst(rst), .cyc_type(cyc_type), .cyc_step(cyc_step),
  .cmd_code(cmd_code), .cmd_req(cmd_req), .setup_done(setup_done)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
  localparam int P       = 8;
  localparam int NREF    = 2;
  localparam int SYNC    = 2;
  localparam int LAT     = P + SYNC + 1;
  localparam logic [2:0] BL = 3'b010;
  localparam logic       BT = 1'b1;
  localparam logic [2:0] CL = 3'd3;
  localparam logic       WB = 1'b1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b1;
  logic [1:0]  cyc = 2'b00;
  logic [3:0]  stp = 4'd0;
  logic [11:0] mode_word;
  logic [1:0]  cmd_code;
  logic        cmd_req;
  logic        setup_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .PWRUP_CYCLES(P), .NUM_REFRESH(NREF), .SYNC_STAGES(SYNC), .STEP_W(4),
    .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL), .WRITE_BURST(WB)
  ) u_sdram_init_seq (
    .clk(clk), .rst(rst), .init_en_async(en), .cyc_type(cyc), .cyc_step(stp),
    .mode_word(mode_word), .cmd_code(cmd_code), .cmd_req(cmd_req), .setup_done(setup_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1; cyc = 2'b00; stp = 4'd0;
    repeat (3) tick();
    chk(!cmd_req && !setup_done && cmd_code == 2'b00, "R1 during reset", {cmd_req, setup_done, cmd_code}, 0);
    rst = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!cmd_req && n < 1000) begin
      tick();
      n++;
      if (!cmd_req) chk(cmd_code == 2'b00, "R2 nop while waiting", cmd_code, 0);
    end
  endtask

  function automatic int exp_op(input int i);
    if (i == 0) return 1;
    if (i == NREF + 1) return 3;
    return 2;
  endfunction

  task automatic serve(input int exp, input int hold, input int busy, input bit last);
    chk(cmd_req == 1'b1, "R5 request present", cmd_req, 1);
    chk(cmd_code == 2'(exp), "R4 code order", cmd_code, exp);
    for (int i = 0; i < hold; i++) begin
      case (i % 3)
        0: begin cyc = 2'b10; stp = 4'd0; end
        1: begin cyc = 2'b11; stp = 4'd0; end
        default: begin cyc = 2'b01; stp = 4'd5; end
      endcase
      tick();
      chk(cmd_req == 1'b1, "R5 held without grant", cmd_req, 1);
      chk(cmd_code == 2'(exp), "R5 code held", cmd_code, exp);
    end
    cyc = 2'b01; stp = 4'd0;
    tick();
    chk(cmd_req == 1'b0, "R6 drop after grant", cmd_req, 0);
    chk(cmd_code == 2'(exp), "R6 code kept", cmd_code, exp);
    for (int i = 0; i < busy; i++) begin
      stp = 4'(i + 1);
      tick();
      chk(!cmd_req && !setup_done && cmd_code == 2'(exp), "R6 no advance while busy",
          {cmd_req, setup_done, cmd_code}, exp);
    end
    cyc = 2'b00; stp = 4'd0;
    tick();
    if (last) begin
      chk(setup_done == 1'b1, "R7 done raised", setup_done, 1);
      chk(!cmd_req && cmd_code == 2'b00, "R7 quiet after done", {cmd_req, cmd_code}, 0);
    end else begin
      chk(cmd_req == 1'b1, "R6 next request", cmd_req, 1);
      chk(!setup_done, "R7 not done early", setup_done, 0);
    end
  endtask

  task automatic run_sequence(input int hold, input int busy);
    for (int s = 0; s < NREF + 2; s++)
      serve(exp_op(s), (hold + s) % 4, busy, s == NREF + 1);
  endtask

  initial begin
    int n;
    // R8 mode word layout
    hold_reset();
    begin
      int expw;
      expw = int'(BL) + (int'(BT) << 3) + (int'(CL) << 4) + (int'(WB) << 9);
      chk(mode_word == 12'(expw), "R8 mode word", mode_word, expw);
      chk(mode_word[8:7] == 2'b00 && mode_word[11:10] == 2'b00, "R8 reserved zero", mode_word, expw);
    end
    // R1 first cycle after reset
    tick();
    chk(!cmd_req && !setup_done && cmd_code == 2'b00, "R1 after release", {cmd_req, setup_done}, 0);

    // R2 latency and R4-R7 sweep over hold-off and busy lengths
    for (int h = 0; h < 3; h++) begin
      for (int b = 0; b < 3; b++) begin
        hold_reset();
        wait_req(n);
        chk(n == LAT, "R2 start latency", n, LAT);
        run_sequence(h, b);
        repeat (10) tick();
        chk(setup_done && !cmd_req, "R7 done sticky", {setup_done, cmd_req}, 2);
      end
    end

    // R3 enable low keeps the block idle
    en = 1'b0;
    hold_reset();
    repeat (40) tick();
    chk(!cmd_req && cmd_code == 2'b00, "R3 idle while disabled", cmd_req, 0);
    en = 1'b1;
    wait_req(n);
    chk(n == LAT, "R3 latency from enable rise", n, LAT);
    run_sequence(1, 1);

    // R10 enable drop after start has no effect
    hold_reset();
    repeat (SYNC + 2) tick();
    en = 1'b0;
    begin
      int m;
      wait_req(m);
      chk(m + SYNC + 2 == LAT, "R10 latency unchanged", m + SYNC + 2, LAT);
    end
    run_sequence(2, 0);
    chk(setup_done == 1'b1, "R10 completes without enable", setup_done, 1);
    en = 1'b1;

    // R9 reset mid-sequence restarts with full delay
    hold_reset();
    wait_req(n);
    serve(1, 0, 1, 1'b0);
    hold_reset();
    chk(!setup_done && !cmd_req, "R9 cleared", {setup_done, cmd_req}, 0);
    wait_req(n);
    chk(n == LAT, "R9 full delay again", n, LAT);
    chk(cmd_code == 2'b01, "R9 restarts at precharge", cmd_code, 1);
    run_sequence(0, 2);
    hold_reset();
    tick();
    chk(!setup_done, "R9 done cleared by reset", setup_done, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule